// File: doc/BRIEF.md
# Compressed Instruction Realigner

This block sits between an instruction fetch path and the decoders of a core that mixes 16-bit compressed and 32-bit full-length instructions. Every cycle it may be handed one word-aligned 32-bit fetch block together with the address the fetch was aimed at. It splits the block into 16-bit parcels and classifies each one. It then presents up to two complete instructions on two output slots, each with its own valid bit and byte address.

A full-length instruction whose first parcel is the upper halfword of a block does not fit in that block. Its first half is held in a one-entry stash until the next block arrives, and is then joined with that block's lower halfword. When the fetch address has bit 1 set, the lower halfword of the block is skipped. A redirect of that kind discards any pending stashed half. A kill input clears the stash and discards the block offered in the same cycle. There is no backpressure: the block accepts one fetch block per cycle and produces its results one cycle later.

Top module: `rvc_realigner`

## Requirements
- R1: After a synchronous reset, both slot valid outputs are low and no half instruction is held. A following aligned full-length block is therefore emitted unchanged.
- R2: A halfword is compressed when its bits [1:0] are not 2'b11. A compressed instruction is output in bits [15:0] of its slot, with bits [31:16] zero.
- R3: When nothing is held and address bit 1 is 0, a full-length lower halfword makes slot 0 carry the whole 32-bit block at the word-aligned fetch address. Slot 1 stays invalid.
- R4: When nothing is held, address bit 1 is 0, and both halfwords are compressed, slot 0 carries the lower halfword at the aligned address. Slot 1 carries the upper halfword at the aligned address plus 2.
- R5: When nothing is held, address bit 1 is 0, the lower halfword is compressed and the upper is not, slot 0 carries the lower halfword and slot 1 stays invalid. The upper halfword is stored as the first half of a pending instruction.
- R6: When a half is held and address bit 1 is 0, slot 0 carries {new lower halfword, held halfword} at the held half's address, which is the previous block's aligned address plus 2. The new upper halfword then goes to slot 1 if compressed, or is held if not.
- R7: When address bit 1 is 1, the lower halfword is ignored. A compressed upper halfword goes to slot 0 at the fetch address, with slot 1 invalid. A full-length upper halfword produces no output and is held for joining with the next block.
- R8: A held half is discarded when the next accepted block has address bit 1 set.
- R9: A kill discards any held half and the block offered in that cycle. Both slots are invalid in the following cycle.
- R10: Outputs are registered, so results appear one cycle after the block is accepted. A cycle without fetch valid gives invalid slots and leaves a held half untouched.
- R11: Slot 1 is valid only when slot 0 is valid, and slot 1 always holds an upper-halfword compressed instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | A fetch block is offered this cycle |
| fetch_addr_i | input | ADDR_W | Fetch address; bit 1 selects the starting halfword |
| fetch_data_i | input | 32 | Word-aligned fetch block |
| kill_i | input | 1 | Discard held half and the current block |
| slot0_valid_o | output | 1 | Slot 0 carries an instruction |
| slot0_addr_o | output | ADDR_W | Byte address of slot 0 instruction |
| slot0_instr_o | output | 32 | Slot 0 instruction |
| slot1_valid_o | output | 1 | Slot 1 carries an instruction |
| slot1_addr_o | output | ADDR_W | Byte address of slot 1 instruction |
| slot1_instr_o | output | 32 | Slot 1 instruction |

## Verification
The only hidden state is the stash, and an error in it shows up at the ports one block later. A stale half shows up as a joined instruction where a plain aligned one was expected. A lost half shows up as a compressed parcel or a whole word appearing at the wrong address. The bench therefore follows every sequence that creates a stash with a block whose output differs depending on whether the stash survived. This covers idle cycles, redirects and kills placed between the two blocks. Slot order and address errors are visible on the same cycle the slots become valid.

// File: rtl/rvc_realign_pkg.sv
package rvc_realign_pkg;
  localparam int HALF_W  = 16;
  localparam int INSTR_W = 2 * HALF_W;

  function automatic logic is_compressed(input logic [1:0] opcode_lsbs);
    return opcode_lsbs != 2'b11;
  endfunction
endpackage

// File: rtl/rvc_parcel_classify.sv
module rvc_parcel_classify
  import rvc_realign_pkg::*;
(
  input  logic [HALF_W-1:0]  parcel_i,
  output logic               cmp_o,
  output logic [INSTR_W-1:0] ext_o
);
  always_comb begin
    cmp_o = is_compressed(parcel_i[1:0]);
    ext_o = {{(INSTR_W-HALF_W){1'b0}}, parcel_i};
  end
endmodule

// File: rtl/rvc_stash.sv
module rvc_stash
  import rvc_realign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [HALF_W-1:0] half_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
    end else if (drop_i) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o <= '0;
      addr_o <= '0;
    end else if (load_i && !kill_i) begin
      half_o <= half_i;
      addr_o <= addr_i;
    end
  end

  // R9: a kill leaves nothing held
  a_r9_kill_clears_stash: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> !valid_o);
  // R5: a held half is always a full-length first half
  a_r5_stash_full_length: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> half_o[1:0] == 2'b11);
endmodule

// File: rtl/rvc_realigner.sv
module rvc_realigner
  import rvc_realign_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid_i,
  input  logic [ADDR_W-1:0]  fetch_addr_i,
  input  logic [INSTR_W-1:0] fetch_data_i,
  input  logic               kill_i,
  output logic               slot0_valid_o,
  output logic [ADDR_W-1:0]  slot0_addr_o,
  output logic [INSTR_W-1:0] slot0_instr_o,
  output logic               slot1_valid_o,
  output logic [ADDR_W-1:0]  slot1_addr_o,
  output logic [INSTR_W-1:0] slot1_instr_o
);
  localparam int NUM_PARCELS = INSTR_W / HALF_W;
  localparam logic [ADDR_W-1:0] WORD_MASK  = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] HALF_STEP  = ADDR_W'(2);

  logic [NUM_PARCELS-1:0]              parcel_cmp;
  logic [NUM_PARCELS-1:0][INSTR_W-1:0] parcel_ext;

  for (genvar p = 0; p < NUM_PARCELS; p++) begin : g_parcel
    rvc_parcel_classify u_cls (
      .parcel_i (fetch_data_i[p*HALF_W +: HALF_W]),
      .cmp_o    (parcel_cmp[p]),
      .ext_o    (parcel_ext[p])
    );
  end

  logic [ADDR_W-1:0] base_addr, hi_addr;
  logic [HALF_W-1:0] lo_half, hi_half;
  logic              take;

  logic              st_valid;
  logic [HALF_W-1:0] st_half;
  logic [ADDR_W-1:0] st_addr;
  logic              st_load, st_drop;

  logic               n_v0, n_v1;
  logic [ADDR_W-1:0]  n_a0, n_a1;
  logic [INSTR_W-1:0] n_i0, n_i1;

  always_comb begin
    base_addr = fetch_addr_i & WORD_MASK;
    hi_addr   = base_addr | HALF_STEP;
    lo_half   = fetch_data_i[HALF_W-1:0];
    hi_half   = fetch_data_i[INSTR_W-1:HALF_W];
    take      = fetch_valid_i && !kill_i;
  end

  always_comb begin
    n_v0 = 1'b0; n_a0 = '0; n_i0 = '0;
    n_v1 = 1'b0; n_a1 = '0; n_i1 = '0;
    st_load = 1'b0;
    st_drop = 1'b0;
    if (take) begin
      if (fetch_addr_i[1]) begin
        st_drop = 1'b1;
        if (parcel_cmp[1]) begin
          n_v0 = 1'b1; n_a0 = hi_addr; n_i0 = parcel_ext[1];
        end else begin
          st_load = 1'b1;
        end
      end else if (!st_valid && !parcel_cmp[0]) begin
        n_v0 = 1'b1; n_a0 = base_addr; n_i0 = fetch_data_i;
      end else begin
        n_v0 = 1'b1;
        if (st_valid) begin
          st_drop = 1'b1;
          n_a0 = st_addr; n_i0 = {lo_half, st_half};
        end else begin
          n_a0 = base_addr; n_i0 = parcel_ext[0];
        end
        if (parcel_cmp[1]) begin
          n_v1 = 1'b1; n_a1 = hi_addr; n_i1 = parcel_ext[1];
        end else begin
          st_load = 1'b1;
        end
      end
    end
  end

  rvc_stash #(.ADDR_W(ADDR_W)) u_stash (
    .clk     (clk),
    .rst     (rst),
    .kill_i  (kill_i),
    .load_i  (st_load),
    .drop_i  (st_drop),
    .half_i  (hi_half),
    .addr_i  (hi_addr),
    .valid_o (st_valid),
    .half_o  (st_half),
    .addr_o  (st_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0_valid_o <= 1'b0; slot0_addr_o <= '0; slot0_instr_o <= '0;
      slot1_valid_o <= 1'b0; slot1_addr_o <= '0; slot1_instr_o <= '0;
    end else begin
      slot0_valid_o <= n_v0; slot0_addr_o <= n_a0; slot0_instr_o <= n_i0;
      slot1_valid_o <= n_v1; slot1_addr_o <= n_a1; slot1_instr_o <= n_i1;
    end
  end

  // R11: slot 1 never valid alone
  a_r11_slot_order: assert property (@(posedge clk) disable iff (rst)
    slot1_valid_o |-> slot0_valid_o);
  // R11: slot 1 is an upper-halfword compressed instruction
  a_r11_slot1_upper_cmp: assert property (@(posedge clk) disable iff (rst)
    slot1_valid_o |-> (slot1_addr_o[1] && slot1_instr_o[1:0] != 2'b11 &&
                       slot1_instr_o[INSTR_W-1:HALF_W] == '0));
  // R2: compressed output on slot 0 is zero-extended
  a_r2_slot0_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (slot0_valid_o && slot0_instr_o[1:0] != 2'b11) |->
      slot0_instr_o[INSTR_W-1:HALF_W] == '0);
  // R10: no fetch, no output next cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_i |=> (!slot0_valid_o && !slot1_valid_o));
  // R9: kill suppresses the next cycle's output
  a_r9_kill_quiet: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> (!slot0_valid_o && !slot1_valid_o));
endmodule

// File: tb/rvc_realigner_tb_top.sv
module rvc_realigner_tb_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid_i;
  logic [AW-1:0] fetch_addr_i;
  logic [31:0]   fetch_data_i;
  logic          kill_i;
  logic          slot0_valid_o, slot1_valid_o;
  logic [AW-1:0] slot0_addr_o, slot1_addr_o;
  logic [31:0]   slot0_instr_o, slot1_instr_o;

  always #5 clk = ~clk;

  rvc_realigner #(.ADDR_W(AW)) dut_i (
    .clk (clk), .rst (rst),
    .fetch_valid_i (fetch_valid_i), .fetch_addr_i (fetch_addr_i),
    .fetch_data_i (fetch_data_i), .kill_i (kill_i),
    .slot0_valid_o (slot0_valid_o), .slot0_addr_o (slot0_addr_o),
    .slot0_instr_o (slot0_instr_o),
    .slot1_valid_o (slot1_valid_o), .slot1_addr_o (slot1_addr_o),
    .slot1_instr_o (slot1_instr_o)
  );

  typedef struct packed {
    logic          v0;
    logic [AW-1:0] a0;
    logic [31:0]   i0;
    logic          v1;
    logic [AW-1:0] a1;
    logic [31:0]   i1;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  task automatic drive(input logic fv, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic k,
                       input logic v0, input logic [AW-1:0] a0, input logic [31:0] i0,
                       input logic v1, input logic [AW-1:0] a1, input logic [31:0] i1,
                       input string tag);
    exp_t e;
    @(negedge clk);
    fetch_valid_i = fv; fetch_addr_i = a; fetch_data_i = d; kill_i = k;
    e.v0 = v0; e.a0 = v0 ? a0 : '0; e.i0 = v0 ? i0 : '0;
    e.v1 = v1; e.a1 = v1 ? a1 : '0; e.i1 = v1 ? i1 : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, tag);
  endtask

  // monitor: compares one expected item per cycle
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  act;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act.v0 = slot0_valid_o;
      act.a0 = slot0_valid_o ? slot0_addr_o : '0;
      act.i0 = slot0_valid_o ? slot0_instr_o : '0;
      act.v1 = slot1_valid_o;
      act.a1 = slot1_valid_o ? slot1_addr_o : '0;
      act.i1 = slot1_valid_o ? slot1_instr_o : '0;
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: got v0=%b a0=%h i0=%h v1=%b a1=%h i1=%h, expected v0=%b a0=%h i0=%h v1=%b a1=%h i1=%h",
                 t, act.v0, act.a0, act.i0, act.v1, act.a1, act.i1,
                 e.v0, e.a0, e.i0, e.v1, e.a1, e.i1);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fetch_valid_i = 1'b0; fetch_addr_i = '0; fetch_data_i = '0; kill_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    checks++; // R1 reset state
    if (slot0_valid_o !== 1'b0 || slot1_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got v0=%b v1=%b, expected 0 0", slot0_valid_o, slot1_valid_o);
    end
    @(negedge clk); rst = 1'b0;

    // R1/R3: aligned full-length, nothing held after reset
    drive(1, 32'h1000, 32'h1234_5673, 0, 1, 32'h1000, 32'h1234_5673, 0, '0, '0, "R1 R3 aligned full");
    // R4/R2: two compressed
    drive(1, 32'h1004, 32'h4581_0505, 0, 1, 32'h1004, 32'h0000_0505, 1, 32'h1006, 32'h0000_4581, "R4 R2 two compressed");
    // R5: compressed then incomplete
    drive(1, 32'h1008, 32'hABC7_8082, 0, 1, 32'h1008, 32'h0000_8082, 0, '0, '0, "R5 cmp plus half");
    // R6: join, then compressed upper
    drive(1, 32'h100C, 32'h0001_1234, 0, 1, 32'h100A, 32'h1234_ABC7, 1, 32'h100E, 32'h0000_0001, "R6 join then cmp");
    // R6: join followed by a new incomplete half, chained
    drive(1, 32'h1010, 32'h5553_0001, 0, 1, 32'h1010, 32'h0000_0001, 0, '0, '0, "R5 setup chain");
    drive(1, 32'h1014, 32'h7777_9999, 0, 1, 32'h1012, 32'h9999_5553, 0, '0, '0, "R6 join then half");
    drive(1, 32'h1018, 32'h0002_1111, 0, 1, 32'h1016, 32'h1111_7777, 1, 32'h101A, 32'h0000_0002, "R6 chained join");
    // R10: idle cycle keeps the held half
    drive(1, 32'h1020, 32'hAAAB_0004, 0, 1, 32'h1020, 32'h0000_0004, 0, '0, '0, "R5 setup idle");
    idle("R10 idle quiet");
    drive(1, 32'h1024, 32'h0008_2222, 0, 1, 32'h1022, 32'h2222_AAAB, 1, 32'h1026, 32'h0000_0008, "R10 held half kept");
    // R7: odd start, compressed upper, lower ignored
    drive(1, 32'h2002, 32'h4505_FFFF, 0, 1, 32'h2002, 32'h0000_4505, 0, '0, '0, "R7 odd cmp");
    // R7: odd start, full upper held then joined
    drive(1, 32'h2006, 32'hCCCF_0000, 0, 0, '0, '0, 0, '0, '0, "R7 odd full no output");
    drive(1, 32'h2008, 32'h0010_DDDD, 0, 1, 32'h2006, 32'hDDDD_CCCF, 1, 32'h200A, 32'h0000_0010, "R7 odd full joined");
    // R8: redirect drops held half
    drive(1, 32'h3000, 32'hEEE3_0014, 0, 1, 32'h3000, 32'h0000_0014, 0, '0, '0, "R5 setup redirect");
    drive(1, 32'h3006, 32'h0018_1113, 0, 1, 32'h3006, 32'h0000_0018, 0, '0, '0, "R8 redirect cmp");
    drive(1, 32'h3008, 32'h0000_4403, 0, 1, 32'h3008, 32'h0000_4403, 0, '0, '0, "R8 held half gone");
    // R9: kill drops held half and current block
    drive(1, 32'h4000, 32'h1237_0020, 0, 1, 32'h4000, 32'h0000_0020, 0, '0, '0, "R5 setup kill");
    drive(1, 32'h4004, 32'h0024_0028, 1, 0, '0, '0, 0, '0, '0, "R9 kill quiet");
    drive(1, 32'h4008, 32'h0000_0093, 0, 1, 32'h4008, 32'h0000_0093, 0, '0, '0, "R9 held half gone");
    // R11 covered by every slot pattern above; finish with an idle
    idle("R10 final idle");
    idle("R11 drain");

    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule